// File: doc/BRIEF.md
# Rotating Off-Time Path Sequencer for an H-Bridge

This block drives the four gate controls of a full H-bridge: high and low switch on side A, high and low switch on side B. It changes which devices carry the motor current during the off-time, one PWM period to the next. The aim is to spread conduction heat evenly over the four switches and their body diodes.

An upstream PWM source provides three inputs:
- a phase input: high during on-time, low during off-time;
- a one-clock strobe in the first clock of each period;
- the drive direction.

A sequence select chooses one of two rotations:
- A two-period synchronous rotation, in which the off-time current alternates between the two high-side switches and the two low-side switches.
- A four-period asynchronous rotation, in which exactly one switch is closed during the off-time. The other off-time current flows through a body diode.

Dead-time insertion happens downstream. Because the gates keep toggling even at zero duty, an explicit enable provides the power-down state.

Top module: `hsp_sequencer`

## Requirements
- R1: During reset and after it, all four gate outputs are 0. They stay 0 until a period strobe is seen while enable is high.
- R2: In forward drive (`dir_fwd`=1), whenever the phase input is high, the outputs are q1=1, q2=0, q3=0, q4=1.
- R3: In the two-period rotation (`seq_quad`=0, forward), the off-time outputs follow a fixed order:
  - slot 1: q1 and q3 are 1;
  - slot 2: q2 and q4 are 1;
  - all other outputs are 0 in both slots;
  - the order repeats. This holds at zero duty as well.
- R4: In the four-period rotation (`seq_quad`=1, forward), exactly one off-time output is 1, in this order by slot: q1, then q3, then q4, then q2.
- R5: In reverse drive (`dir_fwd`=0), every pattern is the forward pattern with q1 and q3 exchanged and q2 and q4 exchanged.
- R6: While enable is low, all outputs are 0 in the same cycle. On re-enable, the outputs stay 0 until the next strobe, and the rotation restarts at slot 1.
- R7: A change of direction or sequence select has no effect on the outputs before the next strobe. At that strobe, the new setting applies and the rotation restarts at slot 1.
- R8: The slot advances only on a strobe. Within one period, the off-time pattern does not change.
- R9: q1 and q2 are never 1 together. q3 and q4 are never 1 together.
- R10: With unchanged settings, the slot wraps from its last value (2 or 4) back to slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_en | input | 1 | Enable; when low, all outputs are forced to 0 |
| period_strobe | input | 1 | High in the first clock of each PWM period |
| on_phase | input | 1 | 1 during on-time, 0 during off-time |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| seq_quad | input | 1 | 0 = two-period rotation, 1 = four-period rotation |
| q1_o | output | 1 | Side A high switch gate |
| q2_o | output | 1 | Side A low switch gate |
| q3_o | output | 1 | Side B high switch gate |
| q4_o | output | 1 | Side B low switch gate |

## Verification
The block takes no parameters. The rotation lengths of two and four are constants, so the bench builds the single fixed configuration. With that configuration, both wrap points can be reached within a few short periods. These include periods of zero duty, which make the off-time rotation visible on every clock. Direction, sequence and enable changes are placed in the middle of periods so that the latching at the strobe and the restart at slot 1 can be seen at the outputs.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int PAIR_LEN = 2;
    localparam int QUAD_LEN = 4;
    localparam int SLOT_W   = $clog2(QUAD_LEN);

    typedef enum logic {
        SEQ_PAIR = 1'b0,
        SEQ_QUAD = 1'b1
    } seq_e;

    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gates_t;

    typedef struct packed {
        logic              active;
        logic              fwd;
        seq_e              seq;
        logic [SLOT_W-1:0] slot;
    } track_t;

    function automatic logic [SLOT_W-1:0] last_slot(seq_e s);
        return (s == SEQ_QUAD) ? SLOT_W'(QUAD_LEN - 1) : SLOT_W'(PAIR_LEN - 1);
    endfunction

    function automatic gates_t mirror(gates_t g);
        gates_t m;
        m.hs_a = g.hs_b;
        m.ls_a = g.ls_b;
        m.hs_b = g.hs_a;
        m.ls_b = g.ls_a;
        return m;
    endfunction

endpackage

// File: rtl/hsp_slot_tracker.sv
module hsp_slot_tracker
    import hsp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   strobe,
    input  logic   dir_fwd,
    input  seq_e   seq_in,
    output track_t state_nxt
);

    track_t cur;

    always_comb begin
        state_nxt = cur;
        if (rst || !en) begin
            state_nxt.active = 1'b0;
            state_nxt.slot   = '0;
        end else if (strobe) begin
            if (!cur.active || cur.fwd != dir_fwd || cur.seq != seq_in) begin
                state_nxt.active = 1'b1;
                state_nxt.fwd    = dir_fwd;
                state_nxt.seq    = seq_in;
                state_nxt.slot   = '0;
            end else if (cur.slot == last_slot(cur.seq)) begin
                state_nxt.slot = '0;
            end else begin
                state_nxt.slot = cur.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= state_nxt;
    end

endmodule

// File: rtl/hsp_gate_map.sv
module hsp_gate_map
    import hsp_pkg::*;
(
    input  track_t st,
    input  logic   on_phase,
    output gates_t gates
);

    gates_t fwd_view;

    always_comb begin
        fwd_view = '0;
        if (on_phase) begin
            fwd_view.hs_a = 1'b1;
            fwd_view.ls_b = 1'b1;
        end else if (st.seq == SEQ_PAIR) begin
            fwd_view.hs_a = (st.slot == '0);
            fwd_view.hs_b = (st.slot == '0);
            fwd_view.ls_a = (st.slot != '0);
            fwd_view.ls_b = (st.slot != '0);
        end else begin
            case (st.slot)
                2'd0:    fwd_view.hs_a = 1'b1;
                2'd1:    fwd_view.hs_b = 1'b1;
                2'd2:    fwd_view.ls_b = 1'b1;
                default: fwd_view.ls_a = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (!st.active)  gates = '0;
        else if (st.fwd) gates = fwd_view;
        else             gates = mirror(fwd_view);
    end

endmodule

// File: rtl/hsp_sequencer.sv
module hsp_sequencer
    import hsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic drive_en,
    input  logic period_strobe,
    input  logic on_phase,
    input  logic dir_fwd,
    input  logic seq_quad,
    output logic q1_o,
    output logic q2_o,
    output logic q3_o,
    output logic q4_o
);

    track_t st_nxt;
    gates_t gates;
    seq_e   seq_sel;

    assign seq_sel = seq_quad ? SEQ_QUAD : SEQ_PAIR;

    hsp_slot_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .en       (drive_en),
        .strobe   (period_strobe),
        .dir_fwd  (dir_fwd),
        .seq_in   (seq_sel),
        .state_nxt(st_nxt)
    );

    hsp_gate_map u_map (
        .st      (st_nxt),
        .on_phase(on_phase),
        .gates   (gates)
    );

    assign q1_o = gates.hs_a;
    assign q2_o = gates.ls_a;
    assign q3_o = gates.hs_b;
    assign q4_o = gates.ls_b;

endmodule

// File: rtl/hsp_sequencer_chk.sv
module hsp_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic drive_en,
    input logic period_strobe,
    input logic on_phase,
    input logic q1_o,
    input logic q2_o,
    input logic q3_o,
    input logic q4_o
);

    logic [3:0] q;
    assign q = {q1_o, q2_o, q3_o, q4_o};

    // R9
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        !(q1_o && q2_o) && !(q3_o && q4_o));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (q == 4'b0000));

    // R2
    on_phase_diag_chk: assert property (@(posedge clk) disable iff (rst)
        on_phase |-> (q == 4'b0000 || q == 4'b1001 || q == 4'b0110));

    // R4
    off_phase_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (!on_phase && q != 4'b0000) |->
            ($countones(q) == 1 || q == 4'b1010 || q == 4'b0101));

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!period_strobe && !on_phase && drive_en && $past(drive_en)
         && $past(!on_phase) && !$past(rst)) |-> $stable(q));

endmodule

bind hsp_sequencer hsp_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .drive_en     (drive_en),
    .period_strobe(period_strobe),
    .on_phase     (on_phase),
    .q1_o         (q1_o),
    .q2_o         (q2_o),
    .q3_o         (q3_o),
    .q4_o         (q4_o)
);

// File: tb/hsp_sequencer_test.sv
`timescale 1ns/1ps
module hsp_sequencer_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic drive_en = 1'b0;
    logic period_strobe = 1'b0;
    logic on_phase = 1'b0;
    logic dir_fwd = 1'b1;
    logic seq_quad = 1'b0;
    logic q1_o, q2_o, q3_o, q4_o;

    always #2.5 clk = ~clk;

    hsp_sequencer uut (
        .clk(clk), .rst(rst), .drive_en(drive_en), .period_strobe(period_strobe),
        .on_phase(on_phase), .dir_fwd(dir_fwd), .seq_quad(seq_quad),
        .q1_o(q1_o), .q2_o(q2_o), .q3_o(q3_o), .q4_o(q4_o)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    // reference state
    bit m_act = 0;
    bit m_dir = 1;
    bit m_quad = 0;
    int m_slot = 0;
    logic [3:0] pair_tab [2];
    logic [3:0] quad_tab [4];
    logic [3:0] exp_q, got_q;
    string req;

    int flip_dir_at = -1;
    int flip_seq_at = -1;
    int drop_at = -1;
    int back_at = -1;

    initial begin
        // order {q1,q2,q3,q4}
        pair_tab[0] = 4'b1010; pair_tab[1] = 4'b0101;
        quad_tab[0] = 4'b1000; quad_tab[1] = 4'b0010;
        quad_tab[2] = 4'b0001; quad_tab[3] = 4'b0100;
    end

    always @(negedge clk) begin
        if (!done) begin
            got_q = {q1_o, q2_o, q3_o, q4_o};
            if (rst || !drive_en) begin
                m_act = 0; m_slot = 0; exp_q = 4'b0000;
                req = rst ? "R1" : "R6";
            end else begin
                if (period_strobe) begin
                    if (!m_act || m_dir != dir_fwd || m_quad != seq_quad) begin
                        m_act = 1; m_dir = dir_fwd; m_quad = seq_quad; m_slot = 0;
                    end else begin
                        m_slot = (m_slot + 1) % (m_quad ? 4 : 2);
                    end
                end
                if (!m_act) begin
                    exp_q = 4'b0000; req = "R1";
                end else begin
                    if (on_phase) begin
                        exp_q = 4'b1001; req = "R2";
                    end else begin
                        exp_q = m_quad ? quad_tab[m_slot] : pair_tab[m_slot];
                        req = m_quad ? "R4" : "R3";
                    end
                    if (!m_dir) begin
                        exp_q = {exp_q[1:0], exp_q[3:2]};
                        req = "R5";
                    end
                end
            end
            vectors++;
            if (got_q !== exp_q) begin
                fails++;
                $display("FAIL %s (%s) t=%0t got=%b expected=%b", req, tag, $time, got_q, exp_q);
            end
            // R9 side exclusivity
            vectors++;
            if ((got_q[3] && got_q[2]) || (got_q[1] && got_q[0])) begin
                fails++;
                $display("FAIL R9 t=%0t got=%b expected=no same-side pair", $time, got_q);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            period_strobe = 1'b0;
        end
    endtask

    task automatic period(input int on_len, input int total);
        for (int k = 0; k < total; k++) begin
            @(posedge clk); #1;
            period_strobe = (k == 0);
            on_phase = (k < on_len);
            if (k == flip_dir_at) dir_fwd = ~dir_fwd;
            if (k == flip_seq_at) seq_quad = ~seq_quad;
            if (k == drop_at) drive_en = 1'b0;
            if (k == back_at) drive_en = 1'b1;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog t=%0t got=hung expected=completion", $time);
            finish_run();
        end
    end

    initial begin
        tag = "R1 reset";
        idle(4);
        @(posedge clk); #1; rst = 1'b0;
        idle(2);
        drive_en = 1'b1;
        tag = "R1 enabled without strobe";
        idle(3);

        tag = "R3 pair forward";
        dir_fwd = 1'b1; seq_quad = 1'b0;
        repeat (4) period(3, 7);
        tag = "R3 pair zero duty R10";
        repeat (3) period(0, 4);

        tag = "R4 quad forward R10";
        seq_quad = 1'b1;
        repeat (6) period(2, 6);
        repeat (4) period(0, 3);

        tag = "R5 quad reverse";
        dir_fwd = 1'b0;
        repeat (5) period(2, 5);
        tag = "R5 pair reverse";
        seq_quad = 1'b0;
        repeat (3) period(1, 5);

        tag = "R7 direction change mid-period";
        flip_dir_at = 3;
        period(1, 8);
        flip_dir_at = -1;
        repeat (3) period(1, 6);
        tag = "R7 sequence change mid-period";
        flip_seq_at = 4;
        period(2, 8);
        flip_seq_at = -1;
        repeat (5) period(2, 6);

        tag = "R6 enable drop and return mid-period";
        drop_at = 2; back_at = 5;
        period(1, 9);
        drop_at = -1; back_at = -1;
        repeat (5) period(1, 6);
        tag = "R6 disabled across strobes";
        drive_en = 1'b0;
        repeat (2) period(2, 5);
        drive_en = 1'b1;
        repeat (3) period(2, 5);

        tag = "R8 long off-time hold";
        repeat (4) period(2, 14);

        idle(2);
        finish_run();
    end

endmodule